// File: doc/BRIEF.md
# Parallel Port Register Interface

This block is the processor-facing side of a 24-line general-purpose parallel I/O unit. It offers three byte-wide ports: A, B and C. Port C is handled as two independent 4-bit halves. A host reaches the ports through a small strobed bus with these signals:
- an active-low select and active-low read and write strobes;
- a 2-bit address;
- a byte-wide data path with a separate output enable for the read data.

All of the block's logic runs on one clock. The strobes are sampled on that clock.

A single configuration address carries two kinds of command, and the top bit of the written byte tells them apart:
- **Mode word.** It sets the direction of each port group for plain, unhandshaked transfers. It also clears every output latch.
- **Bit command.** It sets or clears one line of port C and leaves every other line as it was.

Output values are held in latches. Each pin gets an enable that is high while that pin is configured as an output. Lines configured as inputs are read straight from the pins, without latching. After reset, every line is an input.

Top module: `ppi_regs`

## Requirements
- R1: The address selects the target for both reads and writes: 0 = port A, 1 = port B, 2 = port C, 3 = configuration. A port read of an output port returns that port's latch.
- R2: `dout_oe` is high only while `cs_n`=0, `rd_n`=0 and `wr_n`=1. It is low in every other case, including when the select is high or both strobes are high.
- R3: While `rst`=1, and after it is released, all pin enables are 0, all output latches are 0, and the configuration reads as 0x9B.
- R4: A configuration read returns bit 7 as 1. Bits 6..0 are the last mode word written.
- R5: In the configuration, a bit value of 1 means input and 0 means output. Bit 4 sets the direction of port A, bit 1 of port B, bit 3 of port C lines 7..4, and bit 0 of port C lines 3..0. Each enable bit is 1 exactly when its line is an output.
- R6: A read of a line configured as an input returns the live pin value on that read. Output pins change only on the clock edge that completes a write.
- R7: A configuration write with bit 7 = 1 stores the new mode and clears the latches of ports A, B and C to 0.
- R8: A configuration write with bit 7 = 0 is a bit command. Bits 3..1 select a port C line, and bit 0 is the new value (1 = set, 0 = clear). The other seven port C latch bits are unchanged, and the configuration is unchanged.
- R9: A port C write, and a bit command, change only the port C lines configured as outputs. Input lines keep their latch value.
- R10: A write completes on the first clock edge at which the strobe is seen inactive again after being seen active. A write strobe has no effect while `cs_n`=1 or while `rd_n` is also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| din | input | W | Write data |
| dout | output | W | Read data |
| dout_oe | output | 1 | Read data drive enable |
| pa_in | input | W | Port A pin values |
| pa_out | output | W | Port A latch |
| pa_oe | output | W | Port A per-line output enable |
| pb_in | input | W | Port B pin values |
| pb_out | output | W | Port B latch |
| pb_oe | output | W | Port B per-line output enable |
| pc_in | input | W | Port C pin values |
| pc_out | output | W | Port C latch |
| pc_oe | output | W | Port C per-line output enable |

## Verification
The bench builds the block with the default width W = 8. With that width the bit-command index has three bits, so a sweep of the bit command over all eight port C lines covers both ends of the index, 0 and 7. It also lets the bench use mixed nibble directions, in which a port C write and a bit command must leave the input half of port C untouched.

// File: rtl/ppi_regs.sv
module ppi_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic [1:0]   addr,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dout_oe,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe,
  input  logic [W-1:0] pc_in,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] pc_oe
);
  localparam int N  = W / 2;
  localparam int IW = $clog2(W);
  localparam logic [W-2:0] CFG_RST = (W-1)'(7'b0011011);

  logic [W-2:0] cfg;
  logic [W-1:0] a_lat, b_lat, c_lat, wdat;
  logic [1:0]   wadr;
  logic         wact_q;

  wire wact   = ~cs_n & ~wr_n & rd_n;
  wire commit = wact_q & ~wact;

  wire a_in  = cfg[4];
  wire b_in  = cfg[1];
  wire cu_in = cfg[3];
  wire cl_in = cfg[0];
  wire [W-1:0] c_inmask = {{N{cu_in}}, {N{cl_in}}};
  wire [IW-1:0] sel = wdat[IW:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= CFG_RST;
      a_lat  <= '0;
      b_lat  <= '0;
      c_lat  <= '0;
      wdat   <= '0;
      wadr   <= '0;
      wact_q <= 1'b0;
    end else begin
      wact_q <= wact;
      if (wact) begin
        wadr <= addr;
        wdat <= din;
      end
      if (commit) begin
        case (wadr)
          2'd0: a_lat <= wdat;
          2'd1: b_lat <= wdat;
          2'd2: c_lat <= (c_lat & c_inmask) | (wdat & ~c_inmask);
          default: begin
            if (wdat[W-1]) begin
              cfg   <= wdat[W-2:0];
              a_lat <= '0;
              b_lat <= '0;
              c_lat <= '0;
            end else if (!c_inmask[sel]) begin
              c_lat[sel] <= wdat[0];
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      2'd0:    dout = a_in ? pa_in : a_lat;
      2'd1:    dout = b_in ? pb_in : b_lat;
      2'd2:    dout = (pc_in & c_inmask) | (c_lat & ~c_inmask);
      default: dout = {1'b1, cfg};
    endcase
  end

  assign dout_oe = ~cs_n & ~rd_n & wr_n;
  assign pa_out  = a_lat;
  assign pb_out  = b_lat;
  assign pc_out  = c_lat;
  assign pa_oe   = {W{~a_in}};
  assign pb_oe   = {W{~b_in}};
  assign pc_oe   = ~c_inmask;
endmodule

// File: rtl/ppi_regs_chk.sv
module ppi_regs_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cs_n,
  input logic         rd_n,
  input logic         wr_n,
  input logic [1:0]   addr,
  input logic [W-1:0] dout,
  input logic         dout_oe,
  input logic [W-1:0] pa_out,
  input logic [W-1:0] pa_oe,
  input logic [W-1:0] pb_out,
  input logic [W-1:0] pb_oe,
  input logic [W-1:0] pc_out,
  input logic [W-1:0] pc_oe,
  input logic         commit,
  input logic [1:0]   wadr,
  input logic [W-1:0] wdat
);
  AST_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cs_n || (rd_n && wr_n)) |-> !dout_oe); // R2

  AST_CFG_MSB: assert property (@(posedge clk) disable iff (rst)
    (dout_oe && addr == 2'd3) |-> dout[W-1]); // R4

  AST_RESET_INPUTS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 && pa_out == '0)); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(commit) |-> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out))); // R6

  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(commit && wadr == 2'd3 && wdat[W-1]) |-> (pa_out == '0 && pb_out == '0 && pc_out == '0)); // R7

  AST_BITCMD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $past(commit && wadr == 2'd3 && !wdat[W-1]) |-> ($countones(pc_out ^ $past(pc_out)) <= 1)); // R8

  AST_PC_INPUT_KEEP: assert property (@(posedge clk) disable iff (rst)
    $past(commit && wadr == 2'd2) |-> (((pc_out ^ $past(pc_out)) & ~pc_oe) == '0)); // R9
endmodule

bind ppi_regs ppi_regs_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
  .dout(dout), .dout_oe(dout_oe),
  .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
  .pc_out(pc_out), .pc_oe(pc_oe),
  .commit(commit), .wadr(wadr), .wdat(wdat)
);

// File: tb/ppi_regs_bench.sv
module ppi_regs_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] din = 8'h00;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic       dout_oe;

  int n_chk = 0, n_fail = 0;
  bit running = 0, done = 0;

  always #4 clk = ~clk;

  ppi_regs #(.W(8)) u_ppi_regs (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .din(din), .dout(dout), .dout_oe(dout_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  // behavioural reference model
  bit [6:0] m_cfg;
  bit [7:0] m_a, m_b, m_c, m_dat;
  bit [1:0] m_adr;
  bit       m_pend;

  function automatic bit c_is_in(int i);
    return (i < 4) ? m_cfg[0] : m_cfg[3];
  endfunction

  always @(posedge clk) begin
    bit act;
    act = !cs_n && !wr_n && rd_n;
    if (rst) begin
      m_cfg = 7'h1B; m_a = 0; m_b = 0; m_c = 0; m_pend = 0;
    end else begin
      if (m_pend && !act) begin
        if (m_adr == 2'd0) m_a = m_dat;
        else if (m_adr == 2'd1) m_b = m_dat;
        else if (m_adr == 2'd2) begin
          for (int i = 0; i < 8; i++) if (!c_is_in(i)) m_c[i] = m_dat[i];
        end else if (m_dat[7]) begin
          m_cfg = m_dat[6:0]; m_a = 0; m_b = 0; m_c = 0;
        end else begin
          int k;
          k = int'(m_dat[3:1]);
          if (!c_is_in(k)) m_c[k] = m_dat[0];
        end
      end
      if (act) begin m_adr = addr; m_dat = din; end
      m_pend = act;
    end
  end

  function automatic bit [7:0] m_read(bit [1:0] a);
    bit [7:0] r;
    case (a)
      2'd0: r = m_cfg[4] ? pa_in : m_a;
      2'd1: r = m_cfg[1] ? pb_in : m_b;
      2'd2: for (int i = 0; i < 8; i++) r[i] = c_is_in(i) ? pc_in[i] : m_c[i];
      default: r = {1'b1, m_cfg};
    endcase
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison of pin-side outputs against the model (R5, R6)
  always @(negedge clk) begin
    if (running && !done) begin
      logic [47:0] act, exp;
      bit [7:0] e_pcoe;
      for (int i = 0; i < 8; i++) e_pcoe[i] = !c_is_in(i);
      act = {pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe};
      exp = {m_a, {8{!m_cfg[4]}}, m_b, {8{!m_cfg[1]}}, m_c, e_pcoe};
      chk(act === exp, "R5/R6 per-clock pins", 64'(act), 64'(exp));
    end
  end

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    @(negedge clk); cs_n = 0; addr = a; din = d; wr_n = 0;
    @(negedge clk); wr_n = 1; cs_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(input bit [1:0] a, input string req);
    @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
    #1;
    chk(dout_oe === 1'b1, "R2 oe during read", 64'(dout_oe), 64'd1);
    chk(dout === m_read(a), req, 64'(dout), 64'(m_read(a)));
    #1; rd_n = 1; cs_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1; chk(pa_oe === 0 && pb_oe === 0 && pc_oe === 0, "R3 enables in reset", 64'({pa_oe, pb_oe, pc_oe}), 0);
    rst = 0;
    running = 1;
    @(negedge clk);
    rd(2'd3, "R3 reset config readback");
    chk(m_read(2'd3) == 8'h9B, "R3 reset config value", 64'(m_read(2'd3)), 64'h9B);
    pa_in = 8'h3C; rd(2'd0, "R6 input passthrough A");
    pa_in = 8'hC3; rd(2'd0, "R6 live input A");
    #1; chk(dout_oe === 1'b0, "R2 idle", 64'(dout_oe), 0);

    wr(2'd3, 8'h80);
    chk(pa_oe === 8'hFF && pb_oe === 8'hFF && pc_oe === 8'hFF, "R5 all outputs", 64'({pa_oe, pb_oe, pc_oe}), 64'hFFFFFF);
    wr(2'd0, 8'h5A); wr(2'd1, 8'hA5); wr(2'd2, 8'h3C);
    chk(pa_out === 8'h5A && pb_out === 8'hA5 && pc_out === 8'h3C, "R1 port writes", 64'({pa_out, pb_out, pc_out}), 64'h5AA53C);
    rd(2'd0, "R1 read A latch"); rd(2'd1, "R1 read B latch"); rd(2'd2, "R1 read C latch");

    // R10: ignored writes and commit timing
    @(negedge clk); cs_n = 1; addr = 2'd0; din = 8'hFF; wr_n = 0;
    @(negedge clk); wr_n = 1; @(negedge clk);
    chk(pa_out === 8'h5A, "R10 write with select high ignored", 64'(pa_out), 64'h5A);
    @(negedge clk); cs_n = 0; rd_n = 0; wr_n = 0; din = 8'hFF;
    #1; chk(dout_oe === 1'b0, "R2 both strobes low", 64'(dout_oe), 0);
    @(negedge clk); wr_n = 1; rd_n = 1; cs_n = 1; @(negedge clk);
    chk(pa_out === 8'h5A, "R10 write with read low ignored", 64'(pa_out), 64'h5A);
    @(negedge clk); cs_n = 0; addr = 2'd1; din = 8'h11; wr_n = 0;
    @(negedge clk);
    chk(pb_out === 8'hA5, "R10 no effect while strobe held", 64'(pb_out), 64'hA5);
    wr_n = 1; cs_n = 1;
    @(negedge clk);
    chk(pb_out === 8'h11, "R10 effect after strobe release", 64'(pb_out), 64'h11);

    // R8 bit commands
    wr(2'd3, 8'h0F);
    chk(pc_out === 8'hBC, "R8 set line 7", 64'(pc_out), 64'hBC);
    wr(2'd3, 8'h04);
    chk(pc_out === 8'hB8, "R8 clear line 2", 64'(pc_out), 64'hB8);
    rd(2'd3, "R8 config unchanged by bit command");
    wr(2'd2, 8'h00);
    for (int i = 0; i < 8; i++) begin
      wr(2'd3, 8'((i << 1) | 1));
      chk(pc_out === 8'((1 << (i + 1)) - 1), "R8 sweep set", 64'(pc_out), 64'((1 << (i + 1)) - 1));
    end

    // R7 mode write clears latches; upper C becomes input
    wr(2'd3, 8'h88);
    chk(pa_out === 0 && pb_out === 0 && pc_out === 0, "R7 latches cleared", 64'({pa_out, pb_out, pc_out}), 0);
    chk(pc_oe === 8'h0F && pa_oe === 8'hFF, "R5 mixed C nibbles", 64'({pa_oe, pc_oe}), 64'hFF0F);

    // R9 only output lines of C change
    wr(2'd2, 8'hFF);
    chk(pc_out === 8'h0F, "R9 C write masked", 64'(pc_out), 64'h0F);
    wr(2'd3, 8'h0D);
    chk(pc_out === 8'h0F, "R9 bit command on input line ignored", 64'(pc_out), 64'h0F);
    pc_in = 8'hA0; rd(2'd2, "R9 mixed C read");
    chk(m_read(2'd2) == 8'hAF, "R9 mixed C read value", 64'(m_read(2'd2)), 64'hAF);

    // R4 readback top bit forced; R5 A and B inputs
    wr(2'd3, 8'h92);
    rd(2'd3, "R4 config readback");
    chk(m_read(2'd3) == 8'h92, "R4 readback value", 64'(m_read(2'd3)), 64'h92);
    chk(pa_oe === 0 && pb_oe === 0 && pc_oe === 8'hFF, "R5 A,B input", 64'({pa_oe, pb_oe, pc_oe}), 64'h0000FF);
    pb_in = 8'h77; rd(2'd1, "R6 input B");

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule